// File: doc/BRIEF.md
# Four-Bank Masked Address Decoder

This block sits at the front of an external memory interface and decides which of four banks an incoming bus access belongs to. Each bank holds a base and a mask that cover address bits 31 down to 15, so the smallest bank is 32 KB. It also holds a valid flag, a write-protect flag and a 3-bit code naming the access machine that serves it. For each request the decoder returns a registered one-hot chip-select, the owning machine's code, and two error pulses: one for a write into a protected bank and one for an address that no bank claims.

Bank 0 leaves reset already set up as a boot region over the top 8 MB of the address space, served by the general-purpose machine. Boot fetches therefore decode before any software has written the bank registers. Software then writes one whole bank at a time through a single-cycle write-enable port. The access machines that act on the chip-select are outside this block.

Top module: `mbank_addr_decode`

## Requirements
- R1: After reset, bank 0 is valid, unprotected, uses machine code 0, and has base 0xFF800000 with an 8 MB mask (bits 31:23 compared). Banks 1 to 3 are invalid.
- R2: A valid bank matches when every address bit in 31:15 whose mask bit is 1 equals the base bit. Address bits 14:0 and bits whose mask bit is 0 never affect the result.
- R3: At most one chip-select bit is high, and bit i means bank i was selected.
- R4: When several valid banks match, the bank with the lowest index is selected.
- R5: If the selected bank is write-protected and the request is a write, no chip-select is raised, mach_o is 0 and prot_err_o pulses. A read of the same bank selects it normally.
- R6: A request that matches no bank gives miss_err_o high for one cycle, no chip-select and mach_o 0.
- R7: mach_o carries the selected bank's code: 0 is general-purpose, 1 is NAND, 2 to 4 are the user-programmable machines. A bank whose code is 5 to 7 never matches.
- R8: A bank whose valid flag is 0 never matches.
- R9: The outputs for a request sampled at a clock edge are valid from that edge until the next one. A cycle without req_valid gives all outputs 0.
- R10: A cycle with cfg_we high loads every field of bank cfg_idx. Requests from the following cycle onward decode against the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Bank configuration write strobe |
| cfg_idx | input | 2 | Bank being written |
| cfg_valid | input | 1 | New valid flag |
| cfg_wp | input | 1 | New write-protect flag |
| cfg_mach | input | 3 | New machine code |
| cfg_base | input | 17 | New base, address bits 31:15 |
| cfg_mask | input | 17 | New mask, bits 31:15, 1 = compared |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Request byte address |
| cs_o | output | 4 | One-hot chip-select |
| mach_o | output | 3 | Machine code of selected bank |
| prot_err_o | output | 1 | Protected-write error pulse |
| miss_err_o | output | 1 | No-match error pulse |

## Verification
All four results come from one register stage. A request driven before clock edge k has its chip-select, machine code and both error flags valid between edge k and edge k+1. The bench drives each request at a falling edge, lets one rising edge pass, and compares all four outputs at the next falling edge against its own model. It then withdraws the request so that the idle cycle can be checked too. A configuration write is always followed by at least one full cycle before a request that depends on it.

// File: rtl/mbdec_pkg.sv
package mbdec_pkg;
  localparam int ADDR_W   = 32;
  localparam int GRAN_LSB = 15;
  localparam int FLD_W    = ADDR_W - GRAN_LSB;
  localparam int MACH_W   = 3;
  localparam logic [MACH_W-1:0] MACH_LAST = 3'd4;

  typedef struct packed {
    logic              valid;
    logic              wp;
    logic [MACH_W-1:0] mach;
    logic [FLD_W-1:0]  base;
    logic [FLD_W-1:0]  mask;
  } bank_cfg_t;
endpackage

// File: rtl/mbdec_regfile.sv
module mbdec_regfile
  import mbdec_pkg::*;
#(
  parameter int NBANK = 4,
  parameter logic [FLD_W-1:0] BOOT_BASE = 17'h1FF00,
  parameter logic [FLD_W-1:0] BOOT_MASK = 17'h1FF00,
  localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  bank_cfg_t        wdata,
  output bank_cfg_t        cfg [NBANK]
);
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    bank_cfg_t nxt;
    logic      en;
    bank_cfg_t rst_val;

    always_comb begin
      rst_val = '0;
      if (g == 0) begin
        rst_val.valid = 1'b1;
        rst_val.base  = BOOT_BASE;
        rst_val.mask  = BOOT_MASK;
      end
      en  = we && (idx == IDX_W'(g));
      nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  cfg[g] <= rst_val;
      else if (en) cfg[g] <= nxt;
    end
  end
endmodule

// File: rtl/mbdec_match.sv
module mbdec_match
  import mbdec_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic [FLD_W-1:0] addr_hi,
  input  bank_cfg_t        cfg [NBANK],
  output logic [NBANK-1:0] hit
);
  for (genvar g = 0; g < NBANK; g++) begin : g_cmp
    logic [FLD_W-1:0] diff;
    logic             legal;
    always_comb begin
      diff   = (addr_hi ^ cfg[g].base) & cfg[g].mask;
      legal  = cfg[g].mach <= MACH_LAST;
      hit[g] = cfg[g].valid && legal && (diff == '0);
    end
  end
endmodule

// File: rtl/mbdec_select.sv
module mbdec_select
  import mbdec_pkg::*;
#(
  parameter int NBANK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [NBANK-1:0]  hit,
  input  bank_cfg_t         cfg [NBANK],
  output logic [NBANK-1:0]  cs_q,
  output logic [MACH_W-1:0] mach_q,
  output logic              perr_q,
  output logic              merr_q
);
  logic [NBANK-1:0]  win;
  logic              any;
  logic              win_wp;
  logic [MACH_W-1:0] win_mach;
  logic [NBANK-1:0]  cs_d;
  logic [MACH_W-1:0] mach_d;
  logic              perr_d;
  logic              merr_d;

  always_comb begin
    win      = '0;
    any      = 1'b0;
    win_wp   = 1'b0;
    win_mach = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (hit[i] && !any) begin
        any      = 1'b1;
        win[i]   = 1'b1;
        win_wp   = cfg[i].wp;
        win_mach = cfg[i].mach;
      end
    end
  end

  always_comb begin
    cs_d   = '0;
    mach_d = '0;
    perr_d = 1'b0;
    merr_d = 1'b0;
    if (req_valid) begin
      if (!any) begin
        merr_d = 1'b1;
      end else if (win_wp && req_write) begin
        perr_d = 1'b1;
      end else begin
        cs_d   = win;
        mach_d = win_mach;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '0;
      mach_q <= '0;
      perr_q <= 1'b0;
      merr_q <= 1'b0;
    end else begin
      cs_q   <= cs_d;
      mach_q <= mach_d;
      perr_q <= perr_d;
      merr_q <= merr_d;
    end
  end

  assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_q));
  assert_prot_blocks_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    perr_q |-> (cs_q == '0 && mach_q == '0 && !merr_q));
  assert_miss_blocks_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    merr_q |-> (cs_q == '0 && mach_q == '0));
  assert_legal_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q != '0) |-> (mach_q <= MACH_LAST));
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (cs_q == '0 && !perr_q && !merr_q && mach_q == '0));
  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit[0] && !(req_write && cfg[0].wp)) |=> cs_q[0]);
endmodule

// File: rtl/mbank_addr_decode.sv
module mbank_addr_decode
  import mbdec_pkg::*;
#(
  parameter int NBANK = 4,
  parameter logic [FLD_W-1:0] BOOT_BASE = 17'h1FF00,
  parameter logic [FLD_W-1:0] BOOT_MASK = 17'h1FF00,
  localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic              cfg_wp,
  input  logic [MACH_W-1:0] cfg_mach,
  input  logic [FLD_W-1:0]  cfg_base,
  input  logic [FLD_W-1:0]  cfg_mask,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [NBANK-1:0]  cs_o,
  output logic [MACH_W-1:0] mach_o,
  output logic              prot_err_o,
  output logic              miss_err_o
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  bank_cfg_t        wdata;
  bank_cfg_t        cfg [NBANK];
  logic [NBANK-1:0] hit;
  logic             unused_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    wdata.valid = cfg_valid;
    wdata.wp    = cfg_wp;
    wdata.mach  = cfg_mach;
    wdata.base  = cfg_base;
    wdata.mask  = cfg_mask;
  end

  assign unused_lo = ^req_addr[GRAN_LSB-1:0];

  mbdec_regfile #(.NBANK(NBANK), .BOOT_BASE(BOOT_BASE), .BOOT_MASK(BOOT_MASK)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .idx(cfg_idx),
    .wdata(wdata), .cfg(cfg)
  );

  mbdec_match #(.NBANK(NBANK)) u_match (
    .addr_hi(req_addr[ADDR_W-1:GRAN_LSB]), .cfg(cfg), .hit(hit)
  );

  mbdec_select #(.NBANK(NBANK)) u_sel (
    .clk(clk), .rst_n(rst_sync_n), .req_valid(req_valid), .req_write(req_write),
    .hit(hit), .cfg(cfg), .cs_q(cs_o), .mach_q(mach_o),
    .perr_q(prot_err_o), .merr_q(miss_err_o)
  );

  assert_boot_alive_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (cfg[0].valid && cfg[0].mach == '0));
endmodule

// File: tb/mbank_addr_decode_test.sv
module mbank_addr_decode_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic        cfg_wp = 1'b0;
  logic [2:0]  cfg_mach = '0;
  logic [16:0] cfg_base = '0;
  logic [16:0] cfg_mask = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  cs_o;
  logic [2:0]  mach_o;
  logic        prot_err_o;
  logic        miss_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        m_valid [4];
  logic        m_wp    [4];
  logic [2:0]  m_mach  [4];
  logic [16:0] m_base  [4];
  logic [16:0] m_mask  [4];

  always #5 clk = ~clk;

  mbank_addr_decode uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_valid(cfg_valid), .cfg_wp(cfg_wp), .cfg_mach(cfg_mach),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .cs_o(cs_o), .mach_o(mach_o),
    .prot_err_o(prot_err_o), .miss_err_o(miss_err_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [8:0] predict(input logic [31:0] a, input logic wr);
    logic [3:0] cs = '0;
    logic [2:0] mc = '0;
    logic pe = 1'b0;
    logic me = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (me && m_valid[i] && m_mach[i] <= 3'd4 &&
          (((a[31:15] ^ m_base[i]) & m_mask[i]) == 17'd0)) begin
        me = 1'b0;
        if (m_wp[i] && wr) pe = 1'b1;
        else begin cs[i] = 1'b1; mc = m_mach[i]; end
      end
    end
    return {cs, mc, pe, me};
  endfunction

  task automatic write_bank(input int i, input logic v, input logic w,
                            input logic [2:0] mc, input logic [16:0] b, input logic [16:0] m);
    cfg_we = 1'b1; cfg_idx = 2'(i); cfg_valid = v; cfg_wp = w;
    cfg_mach = mc; cfg_base = b; cfg_mask = m;
    @(negedge clk);
    cfg_we = 1'b0;
    m_valid[i] = v; m_wp[i] = w; m_mach[i] = mc; m_base[i] = b; m_mask[i] = m;
  endtask

  task automatic access(input string tag, input logic [31:0] a, input logic wr);
    logic [8:0] e;
    e = predict(a, wr);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " cs"},   32'(cs_o),       32'(e[8:5]));
    chk({tag, " mach"}, 32'(mach_o),     32'(e[4:2]));
    chk({tag, " perr"}, 32'(prot_err_o), 32'(e[1]));
    chk({tag, " merr"}, 32'(miss_err_o), 32'(e[0]));
    @(negedge clk);
    chk({tag, " idle R9"}, {26'd0, cs_o, prot_err_o, miss_err_o}, 32'd0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [16:0] mk_mask(input int k);
    logic [16:0] ones = '1;
    return ones << (17 - k);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240613));
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 1'b0; m_wp[i] = 1'b0; m_mach[i] = '0; m_base[i] = '0; m_mask[i] = '0;
    end
    m_valid[0] = 1'b1; m_base[0] = 17'h1FF00; m_mask[0] = 17'h1FF00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("reset outputs R9", {25'd0, cs_o, mach_o}, 32'd0);

    access("boot base R1", 32'hFF80_0000, 1'b0);
    chk("boot cs R1", 32'(cs_o), 32'd0);
    req_valid = 1'b1; req_addr = 32'hFFFF_FFFF; req_write = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("boot top write R1", 32'(cs_o), 32'd1);
    chk("boot top mach R1", 32'(mach_o), 32'd0);
    @(negedge clk);
    access("below boot R6", 32'hFF7F_FFFF, 1'b0);
    access("low bits ignored R2", 32'hFFC0_7FFF, 1'b0);

    write_bank(1, 1'b1, 1'b0, 3'd1, 17'h00020, mk_mask(12));
    write_bank(2, 1'b1, 1'b1, 3'd2, 17'h00000, mk_mask(8));
    write_bank(3, 1'b0, 1'b0, 3'd3, 17'h01000, mk_mask(17));
    @(negedge clk);
    access("nand bank R7", 32'h0010_0010, 1'b0);
    chk("nand mach R7", 32'(predict(32'h0010_0010, 1'b0) >> 2 & 9'h7), 32'd1);
    access("overlap lowest R4", 32'h0010_1234, 1'b1);
    access("protected write R5", 32'h0040_0000, 1'b1);
    access("protected read R5", 32'h0040_0000, 1'b0);
    access("invalid bank R8", 32'h0800_0000, 1'b0);
    write_bank(1, 1'b1, 1'b0, 3'd6, 17'h00020, mk_mask(12));
    @(negedge clk);
    access("reserved code R7", 32'h0010_0000, 1'b0);
    write_bank(0, 1'b1, 1'b0, 3'd4, 17'h00020, mk_mask(17));
    access("new cfg next cycle R10", 32'h0010_0000, 1'b0);
    access("old boot gone R10", 32'hFF80_0000, 1'b0);

    for (int n = 0; n < 400; n++) begin
      if ((n % 40) == 0) begin
        for (int b = 0; b < 4; b++)
          write_bank(b, ($urandom % 4) != 0, ($urandom % 3) == 0, 3'($urandom % 8),
                     17'($urandom), mk_mask(1 + ($urandom % 17)));
        @(negedge clk);
      end
      begin
        logic [31:0] a;
        int b = $urandom % 4;
        if ($urandom % 2) a = {m_base[b] ^ (17'($urandom) & ~m_mask[b]), 15'($urandom)};
        else a = $urandom;
        access("random R2 R3 R4 R5 R6 R7", a, 1'($urandom));
      end
    end

    done = 1'b1;
    summary();
  end
endmodule